// File: doc/BRIEF.md
# LUT Duty Ramp Sequencer

This block walks a PWM duty value through a window of a small on-chip table so that an LED or similar load can blink, fade or "breathe" without host involvement. A host fills the 64-entry table of 9-bit duty values through a two-byte write port. It selects a window with a low and a high index, picks a direction, optional looping and optional ping-pong reversal, and a step time. It then raises the run request. The sequencer holds each entry for the chosen number of 1 kHz ticks and can dwell longer at either end of the window. It presents the current entry on `duty` for a separate PWM counter to consume.

Step times come from a fixed non-linear code table. Codes 0 to 4 give 0 to 4 ms. The remaining codes are 5→6, 6→8, 7→16, 8→18, 9→24, 10→32, 11→36, 12→64, 13→128, 14→256 and 15→512 ms. An end pause multiplies the step time by a factor that depends on a 6-bit code. Codes 0 to 15 give code+1. Codes 38 to 44 give 1000 plus 100 per code above 38. Codes 47 to 56 give 2500 plus 500 per code above 47. The codes between those bands are fixed points: 16→23, 17→28, 18→31, 19→42, 20→47, 21→56, 22→63, 23→83, 24→94, 25→111, 26→125, 27→167, 28→188, 29→222, 30→250, 31→333, 32→375, 33→500, 34→667, 35→750, 36→800, 37→900, 45→1800 and 46→2000. Codes above 56 saturate at 7000.

Top module: `lutseq_ramp`

## Requirements
- R1: After a synchronous reset, `duty` is 0 and `busy` is 0.
- R2: A write of the low byte only stages value bits 7..0. A write of the high byte commits an entry. In that byte, bit 7 is value bit 8 and bits 5..0 are the table index. A staged low byte without a following high byte changes no entry.
- R3: A run starts only when both `gen_en` and `start` are 1 while the sequencer is idle. On the next clock `busy` is 1 and `duty` shows the starting entry.
- R4: Each entry is held for the number of ticks that the step code gives (table above). The next entry appears on the clock edge that takes the last tick of the hold.
- R5: With `ramp_up` = 1 the walk starts at the low index and moves upward. With `ramp_up` = 0 it starts at the high index and moves downward.
- R6: In one-shot mode (`loop_en` = 0), after the final entry's hold, `busy` clears and `duty` keeps the final entry. No new run begins until the run request has dropped.
- R7: With `loop_en` = 1 and `reverse` = 0, after the far-end entry the walk jumps back to the starting end and continues for as long as the run request stays up.
- R8: With `reverse` = 1 the walk turns at the far end and steps back toward the start without repeating the far entry. A one-shot run ends after holding the starting entry again. A looping run turns again there.
- R9: When a pause enable is set, the entry at that end of the window (high or low) is held for step time × pause multiplier ticks, with the multiplier from the pause code table.
- R10: Clearing either `gen_en` or `start` stops the run. `busy` is 0 on the next clock and `duty` keeps its value.
- R11: Step code 0 holds the starting entry for ever. `busy` stays 1 and ticks have no effect on `duty`.
- R12: If the low index exceeds the high index, the window is the single entry at the low index.
- R13: `duty` changes only on the clock edge that starts a run or that takes a tick ending a hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_lo_we | input | 1 | Stage the low value byte |
| tbl_lo_byte | input | 8 | Value bits 7..0 |
| tbl_hi_we | input | 1 | Commit a table entry |
| tbl_hi_byte | input | 8 | Bit 7 value bit 8, bits 5..0 index |
| idx_lo | input | 6 | Low end of the window |
| idx_hi | input | 6 | High end of the window |
| ramp_up | input | 1 | Walk low to high when 1 |
| reverse | input | 1 | Ping-pong at the far end |
| loop_en | input | 1 | Repeat for ever |
| step_code | input | 4 | Step-time code |
| pause_hi_en | input | 1 | Extra dwell at the high end |
| pause_hi_code | input | 6 | High-end pause multiplier code |
| pause_lo_en | input | 1 | Extra dwell at the low end |
| pause_lo_code | input | 6 | Low-end pause multiplier code |
| gen_en | input | 1 | Ramp generator enable |
| start | input | 1 | Ramp start |
| tick_1k | input | 1 | One-cycle pulse per millisecond |
| duty | output | 9 | Current duty value |
| busy | output | 1 | A run is in progress |

## Verification
The assertions assume that the window indices, direction, reverse and loop flags stay unchanged while `busy` is high. They also assume that `rst` is high at time zero and that `tick_1k` is a single-cycle pulse. The bench changes configuration only after it has seen `busy` low and has dropped the run request. Ticks are one clock wide and separated by idle clocks, and the bench leaves the table untouched during a run.

// File: rtl/lutseq_pkg.sv
package lutseq_pkg;

    localparam int IDX_W  = 6;
    localparam int VAL_W  = 9;
    localparam int STEP_W = 10;
    localparam int MULT_W = 13;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic ramp_up;
        logic reverse;
        logic loop_en;
    } walk_cfg_t;

    // Milliseconds held per entry for each step code.
    function automatic logic [STEP_W-1:0] step_ms(input logic [3:0] code);
        logic [STEP_W-1:0] r;
        case (code)
            4'd0:  r = 10'd0;
            4'd1:  r = 10'd1;
            4'd2:  r = 10'd2;
            4'd3:  r = 10'd3;
            4'd4:  r = 10'd4;
            4'd5:  r = 10'd6;
            4'd6:  r = 10'd8;
            4'd7:  r = 10'd16;
            4'd8:  r = 10'd18;
            4'd9:  r = 10'd24;
            4'd10: r = 10'd32;
            4'd11: r = 10'd36;
            4'd12: r = 10'd64;
            4'd13: r = 10'd128;
            4'd14: r = 10'd256;
            default: r = 10'd512;
        endcase
        return r;
    endfunction

    // End-pause multiplier of the step time for each pause code.
    function automatic logic [MULT_W-1:0] pause_mult(input logic [5:0] code);
        int unsigned c;
        int unsigned m;
        c = 32'(code);
        if (c < 16)
            m = c + 1;
        else if (c >= 56)
            m = 7000;
        else if (c >= 47)
            m = 2500 + (c - 47) * 500;
        else if (c >= 38 && c <= 44)
            m = 1000 + (c - 38) * 100;
        else begin
            case (c)
                16: m = 23;   17: m = 28;   18: m = 31;   19: m = 42;
                20: m = 47;   21: m = 56;   22: m = 63;   23: m = 83;
                24: m = 94;   25: m = 111;  26: m = 125;  27: m = 167;
                28: m = 188;  29: m = 222;  30: m = 250;  31: m = 333;
                32: m = 375;  33: m = 500;  34: m = 667;  35: m = 750;
                36: m = 800;  37: m = 900;  45: m = 1800; 46: m = 2000;
                default: m = 1;
            endcase
        end
        return MULT_W'(m);
    endfunction

endpackage

// File: rtl/lutseq_table.sv
module lutseq_table
    import lutseq_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int VW = VAL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lo_we,
    input  logic [7:0]    lo_byte,
    input  logic          hi_we,
    input  logic [7:0]    hi_byte,
    input  logic [IW-1:0] rd_idx,
    output logic [VW-1:0] rd_val
);
    localparam int DEPTH = 1 << IW;
    localparam int LO_W  = VW - 1;

    logic [LO_W-1:0] stage_q;
    logic [VW-1:0]   mem_q [DEPTH];
    logic            unused_hi_bit6;

    assign unused_hi_bit6 = hi_byte[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (lo_we) stage_q <= lo_byte[LO_W-1:0];
            if (hi_we) mem_q[hi_byte[IW-1:0]] <= {hi_byte[7], stage_q};
        end
    end

    assign rd_val = mem_q[rd_idx];
endmodule

// File: rtl/lutseq_dwell.sv
module lutseq_dwell
    import lutseq_pkg::*;
#(
    parameter int SW = STEP_W,
    parameter int MW = MULT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [SW-1:0] step_len,
    input  logic [MW-1:0] reps,
    output logic          expire
);
    logic [SW-1:0] step_cnt_q;
    logic [MW-1:0] rep_cnt_q;
    logic          step_last;
    logic          rep_last;
    logic          counting;

    assign counting  = tick && (step_len != '0);
    assign step_last = (step_cnt_q == step_len - SW'(1));
    assign rep_last  = (rep_cnt_q == reps - MW'(1)) || (reps == '0);
    assign expire    = counting && step_last && rep_last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            step_cnt_q <= '0;
            rep_cnt_q  <= '0;
        end else if (counting) begin
            if (step_last) begin
                step_cnt_q <= '0;
                rep_cnt_q  <= rep_last ? '0 : rep_cnt_q + MW'(1);
            end else begin
                step_cnt_q <= step_cnt_q + SW'(1);
            end
        end
    end
endmodule

// File: rtl/lutseq_walker.sv
module lutseq_walker
    import lutseq_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_req,
    input  logic          expire,
    input  logic [IW-1:0] lo_eff,
    input  logic [IW-1:0] hi_eff,
    input  walk_cfg_t     cfg,
    output logic [IW-1:0] pos_q,
    output logic [IW-1:0] pos_nxt,
    output logic          move,
    output logic          busy
);
    seq_state_e    state_q, state_nxt;
    logic          dir_q, dir_nxt;
    logic          at_far;
    logic          single;
    logic [IW-1:0] fwd_pos;
    logic [IW-1:0] back_pos;
    logic [IW-1:0] home_pos;

    assign single   = (lo_eff == hi_eff);
    assign at_far   = dir_q ? (pos_q == hi_eff) : (pos_q == lo_eff);
    assign fwd_pos  = dir_q ? pos_q + IW'(1) : pos_q - IW'(1);
    assign back_pos = single ? pos_q : (dir_q ? pos_q - IW'(1) : pos_q + IW'(1));
    assign home_pos = cfg.ramp_up ? lo_eff : hi_eff;

    always_comb begin
        state_nxt = state_q;
        pos_nxt   = pos_q;
        dir_nxt   = dir_q;
        move      = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (run_req) begin
                    state_nxt = ST_RUN;
                    pos_nxt   = home_pos;
                    dir_nxt   = cfg.ramp_up;
                    move      = 1'b1;
                end
            end
            ST_RUN: begin
                if (!run_req) begin
                    state_nxt = ST_IDLE;
                end else if (expire) begin
                    if (!at_far) begin
                        pos_nxt = fwd_pos;
                        move    = 1'b1;
                    end else if (cfg.reverse && (dir_q == cfg.ramp_up || cfg.loop_en)) begin
                        dir_nxt = ~dir_q;
                        pos_nxt = back_pos;
                        move    = 1'b1;
                    end else if (!cfg.reverse && cfg.loop_en) begin
                        pos_nxt = home_pos;
                        move    = 1'b1;
                    end else begin
                        state_nxt = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                if (!run_req) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            dir_q   <= 1'b1;
        end else begin
            state_q <= state_nxt;
            pos_q   <= pos_nxt;
            dir_q   <= dir_nxt;
        end
    end

    assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/lutseq_ramp.sv
module lutseq_ramp
    import lutseq_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int VW = VAL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tbl_lo_we,
    input  logic [7:0]    tbl_lo_byte,
    input  logic          tbl_hi_we,
    input  logic [7:0]    tbl_hi_byte,
    input  logic [IW-1:0] idx_lo,
    input  logic [IW-1:0] idx_hi,
    input  logic          ramp_up,
    input  logic          reverse,
    input  logic          loop_en,
    input  logic [3:0]    step_code,
    input  logic          pause_hi_en,
    input  logic [5:0]    pause_hi_code,
    input  logic          pause_lo_en,
    input  logic [5:0]    pause_lo_code,
    input  logic          gen_en,
    input  logic          start,
    input  logic          tick_1k,
    output logic [VW-1:0] duty,
    output logic          busy
);
    logic [IW-1:0]     lo_eff, hi_eff;
    logic [IW-1:0]     pos_q, pos_nxt;
    logic              move;
    logic              expire;
    logic [VW-1:0]     rd_val;
    logic [VW-1:0]     duty_q;
    logic [MULT_W-1:0] reps;
    walk_cfg_t         cfg;

    assign lo_eff = idx_lo;
    assign hi_eff = (idx_lo > idx_hi) ? idx_lo : idx_hi;
    assign cfg    = '{ramp_up: ramp_up, reverse: reverse, loop_en: loop_en};

    always_comb begin
        reps = MULT_W'(1);
        if (pause_hi_en && pos_q == hi_eff)
            reps = pause_mult(pause_hi_code);
        else if (pause_lo_en && pos_q == lo_eff)
            reps = pause_mult(pause_lo_code);
    end

    lutseq_table #(.IW(IW), .VW(VW)) u_table (
        .clk     (clk),
        .rst     (rst),
        .lo_we   (tbl_lo_we),
        .lo_byte (tbl_lo_byte),
        .hi_we   (tbl_hi_we),
        .hi_byte (tbl_hi_byte),
        .rd_idx  (pos_nxt),
        .rd_val  (rd_val)
    );

    lutseq_dwell #(.SW(STEP_W), .MW(MULT_W)) u_dwell (
        .clk      (clk),
        .rst      (rst),
        .clr      (move || !busy),
        .tick     (tick_1k),
        .step_len (step_ms(step_code)),
        .reps     (reps),
        .expire   (expire)
    );

    lutseq_walker #(.IW(IW)) u_walker (
        .clk     (clk),
        .rst     (rst),
        .run_req (gen_en && start),
        .expire  (expire),
        .lo_eff  (lo_eff),
        .hi_eff  (hi_eff),
        .cfg     (cfg),
        .pos_q   (pos_q),
        .pos_nxt (pos_nxt),
        .move    (move),
        .busy    (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)       duty_q <= '0;
        else if (move) duty_q <= rd_val;
    end

    assign duty = duty_q;
endmodule

// File: rtl/lutseq_ramp_chk.sv
module lutseq_ramp_chk #(
    parameter int IW = 6,
    parameter int VW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          gen_en,
    input logic          start,
    input logic          tick_1k,
    input logic [3:0]    step_code,
    input logic [IW-1:0] idx_lo,
    input logic [IW-1:0] idx_hi,
    input logic [IW-1:0] pos,
    input logic [VW-1:0] duty,
    input logic          busy
);
    logic [IW-1:0] top_idx;
    assign top_idx = (idx_lo > idx_hi) ? idx_lo : idx_hi;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && duty == '0));

    a_r3_start_needs_both: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(gen_en && start));

    a_r6_end_holds_duty: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $stable(duty));

    a_r10_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
        !(gen_en && start) |=> !busy);

    a_r11_code0_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && step_code == 4'd0) |=> $stable(duty));

    a_r12_pos_in_window: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pos >= idx_lo && pos <= top_idx));

    a_r13_no_tick_no_change: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_1k) |=> $stable(duty));
endmodule

bind lutseq_ramp lutseq_ramp_chk #(.IW(IW), .VW(VW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gen_en    (gen_en),
    .start     (start),
    .tick_1k   (tick_1k),
    .step_code (step_code),
    .idx_lo    (idx_lo),
    .idx_hi    (idx_hi),
    .pos       (pos_q),
    .duty      (duty),
    .busy      (busy)
);

// File: tb/tb_lutseq_ramp.sv
`timescale 1ns/1ps
module tb_lutseq_ramp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tbl_lo_we = 0, tbl_hi_we = 0;
    logic [7:0] tbl_lo_byte = 0, tbl_hi_byte = 0;
    logic [5:0] idx_lo = 0, idx_hi = 0;
    logic       ramp_up = 1, reverse = 0, loop_en = 0;
    logic [3:0] step_code = 1;
    logic       pause_hi_en = 0, pause_lo_en = 0;
    logic [5:0] pause_hi_code = 0, pause_lo_code = 0;
    logic       gen_en = 0, start = 0, tick_1k = 0;
    logic [8:0] duty;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [8:0] exp_d[$];
    logic       exp_b[$];
    string      exp_tag[$];
    event       chk_ev;

    always #5 clk = ~clk;

    lutseq_ramp dut (
        .clk(clk), .rst(rst),
        .tbl_lo_we(tbl_lo_we), .tbl_lo_byte(tbl_lo_byte),
        .tbl_hi_we(tbl_hi_we), .tbl_hi_byte(tbl_hi_byte),
        .idx_lo(idx_lo), .idx_hi(idx_hi),
        .ramp_up(ramp_up), .reverse(reverse), .loop_en(loop_en),
        .step_code(step_code),
        .pause_hi_en(pause_hi_en), .pause_hi_code(pause_hi_code),
        .pause_lo_en(pause_lo_en), .pause_lo_code(pause_lo_code),
        .gen_en(gen_en), .start(start), .tick_1k(tick_1k),
        .duty(duty), .busy(busy)
    );

    function automatic logic [8:0] v(input int i);
        return 9'((i * 83 + 300) % 512);
    endfunction

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_d.size() > 0) begin
                logic [8:0] d;
                logic       b;
                string      t;
                d = exp_d.pop_front();
                b = exp_b.pop_front();
                t = exp_tag.pop_front();
                checks++;
                if (duty !== d || busy !== b) begin
                    errors++;
                    $display("FAIL %s: duty=%h busy=%b expected duty=%h busy=%b",
                             t, duty, busy, d, b);
                end
            end
        end
    end

    task automatic expect_o(input logic [8:0] d, input logic b, input string t);
        exp_d.push_back(d);
        exp_b.push_back(b);
        exp_tag.push_back(t);
        -> chk_ev;
    endtask

    task automatic wr_lo(input logic [7:0] b);
        @(negedge clk); tbl_lo_we = 1; tbl_lo_byte = b;
        @(negedge clk); tbl_lo_we = 0;
    endtask

    task automatic wr_entry(input int idx, input logic [8:0] val);
        wr_lo(val[7:0]);
        tbl_hi_we = 1; tbl_hi_byte = {val[8], 1'b0, 6'(idx)};
        @(negedge clk); tbl_hi_we = 0;
    endtask

    task automatic cfg(input int lo, input int hi, input bit up, input bit rev,
                       input bit lp, input int sc);
        @(negedge clk);
        idx_lo = 6'(lo); idx_hi = 6'(hi);
        ramp_up = up; reverse = rev; loop_en = lp; step_code = 4'(sc);
        pause_hi_en = 0; pause_lo_en = 0;
    endtask

    task automatic run(input bit on);
        @(negedge clk); gen_en = on; start = on;
        @(negedge clk);
    endtask

    task automatic tk();
        @(negedge clk); tick_1k = 1;
        @(negedge clk); tick_1k = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_o(9'd0, 1'b0, "R1 reset state");

        for (int i = 0; i < 64; i++) wr_entry(i, v(i));

        // R3: gen_en alone does not start a run
        @(negedge clk); gen_en = 1; start = 0;
        @(negedge clk); tk();
        expect_o(9'd0, 1'b0, "R3 gen_en alone");
        gen_en = 0;

        // R2: commit byte, then a staged low byte alone changes nothing
        wr_entry(3, 9'h155);
        wr_lo(8'hAA);
        cfg(3, 3, 1, 0, 0, 1);
        run(1);
        expect_o(9'h155, 1'b1, "R2 committed entry");
        run(0);
        expect_o(9'h155, 1'b0, "R10 stop after single");
        wr_entry(3, v(3));

        // R5 up, R4 step, R6 one-shot end
        cfg(2, 5, 1, 0, 0, 1);
        run(1); expect_o(v(2), 1'b1, "R3 start at low");
        tk(); expect_o(v(3), 1'b1, "R4 step up");
        tk(); expect_o(v(4), 1'b1, "R5 up");
        tk(); expect_o(v(5), 1'b1, "R5 up high end");
        tk(); expect_o(v(5), 1'b0, "R6 one-shot done");
        tk(); expect_o(v(5), 1'b0, "R6 no restart");
        run(0); expect_o(v(5), 1'b0, "R6 idle");

        // R5 downward
        cfg(2, 5, 0, 0, 0, 1);
        run(1); expect_o(v(5), 1'b1, "R5 start at high");
        tk(); expect_o(v(4), 1'b1, "R5 down");
        tk(); expect_o(v(3), 1'b1, "R5 down");
        tk(); expect_o(v(2), 1'b1, "R5 down low end");
        tk(); expect_o(v(2), 1'b0, "R6 down done");
        run(0);

        // R7 loop restart
        cfg(2, 4, 1, 0, 1, 1);
        run(1); expect_o(v(2), 1'b1, "R7 start");
        tk(); expect_o(v(3), 1'b1, "R7 step");
        tk(); expect_o(v(4), 1'b1, "R7 far");
        tk(); expect_o(v(2), 1'b1, "R7 wrap to start");
        tk(); expect_o(v(3), 1'b1, "R7 continue");
        run(0); expect_o(v(3), 1'b0, "R10 stop loop");
        tk(); expect_o(v(3), 1'b0, "R10 tick after stop");

        // R8 reverse loop
        cfg(2, 4, 1, 1, 1, 1);
        run(1); expect_o(v(2), 1'b1, "R8 start");
        tk(); expect_o(v(3), 1'b1, "R8 out");
        tk(); expect_o(v(4), 1'b1, "R8 far");
        tk(); expect_o(v(3), 1'b1, "R8 bounce");
        tk(); expect_o(v(2), 1'b1, "R8 back home");
        tk(); expect_o(v(3), 1'b1, "R8 turn again");
        run(0);

        // R8 reverse one-shot
        cfg(2, 4, 1, 1, 0, 1);
        run(1); expect_o(v(2), 1'b1, "R8 os start");
        tk(); tk(); expect_o(v(4), 1'b1, "R8 os far");
        tk(); expect_o(v(3), 1'b1, "R8 os back");
        tk(); expect_o(v(2), 1'b1, "R8 os home");
        tk(); expect_o(v(2), 1'b0, "R8 os done");
        run(0);

        // R4 two-millisecond step
        cfg(2, 3, 1, 0, 0, 2);
        run(1); expect_o(v(2), 1'b1, "R4 2ms start");
        tk(); expect_o(v(2), 1'b1, "R4 2ms hold");
        tk(); expect_o(v(3), 1'b1, "R4 2ms advance");
        tk(); expect_o(v(3), 1'b1, "R4 2ms hold end");
        tk(); expect_o(v(3), 1'b0, "R4 2ms done");
        run(0);

        // R11 step code 0
        cfg(2, 5, 1, 0, 1, 0);
        run(1);
        tk(); tk(); tk();
        expect_o(v(2), 1'b1, "R11 code0 holds");
        run(0);

        // R12 low index above high index
        cfg(6, 3, 1, 0, 0, 1);
        run(1); expect_o(v(6), 1'b1, "R12 single up");
        tk(); expect_o(v(6), 1'b0, "R12 single done");
        run(0);
        cfg(6, 3, 0, 0, 0, 1);
        run(1); expect_o(v(6), 1'b1, "R12 single down");
        run(0);

        // R9 high-end pause, code 2 -> x3
        cfg(2, 3, 1, 0, 0, 1);
        pause_hi_en = 1; pause_hi_code = 6'd2;
        run(1); expect_o(v(2), 1'b1, "R9 hi start");
        tk(); expect_o(v(3), 1'b1, "R9 hi arrive");
        tk(); tk(); expect_o(v(3), 1'b1, "R9 hi dwell");
        tk(); expect_o(v(3), 1'b0, "R9 hi dwell over");
        run(0);

        // R9 low-end pause, code 16 -> x23
        cfg(2, 3, 0, 0, 0, 1);
        pause_lo_en = 1; pause_lo_code = 6'd16;
        run(1); expect_o(v(3), 1'b1, "R9 lo start");
        tk(); expect_o(v(2), 1'b1, "R9 lo arrive");
        for (int k = 0; k < 22; k++) tk();
        expect_o(v(2), 1'b1, "R9 lo still dwelling");
        tk(); expect_o(v(2), 1'b0, "R9 lo dwell over");
        run(0);

        @(negedge clk);
        #1;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule